// File: doc/BRIEF.md
# Pixel Data Dither Generator

This block adds a small pseudo-random offset to every valid pixel of a digitised video stream, so that quantisation steps in smooth gradients are broken up. A 16-bit linear feedback shift register supplies the random value. The low bits of its current state are read as a signed offset and added to the pixel. The sum is then clamped to the legal output code range. Every accepted pixel appears at the output exactly one clock later, and the output valid flag follows the input valid flag with the same delay.

The shift register can advance on one of three events, selected by a 2-bit rate field: each valid pixel, each line (the rising edge of the horizontal sync input) or each frame (the rising edge of the vertical sync input). A seed-clear control returns the register to its fixed seed. Software pulses that control high and then low, and the sequence starts again from the seed. When dither is switched off, pixels pass through unchanged, still with one cycle of latency.

Top module: `pixel_dither_gen`

## Requirements
- R1: With `dith_en` low, `out_data` equals the `in_data` of one cycle earlier, and `out_valid` always equals `in_valid` of one cycle earlier.
- R2: With `dith_en` high and `amp_sel` = 0, the offset is bits [3:0] of the current PRNG state read as a signed two's-complement value (range -8..+7).
- R3: With `dith_en` high and `amp_sel` = 1, the offset is bits [1:0] of the current PRNG state read as signed two's complement (range -2..+1).
- R4: The sum of pixel and offset is clamped to 0..2^DATA_W-1 (0..255 by default).
- R5: With `rate_sel` = 00, the PRNG advances once per cycle in which `in_valid` is high, and never otherwise.
- R6: With `rate_sel` = 01, the PRNG advances only in a cycle where `hsync` is high and was low in the previous cycle.
- R7: With `rate_sel` = 10 or 11, the PRNG advances only in a cycle where `vsync` is high and was low in the previous cycle.
- R8: While `seed_clr` is high, the PRNG is loaded with the seed 16'hACE1 on every clock. This takes priority over advancing. After release, the sequence resumes from the seed.
- R9: One advance shifts the state left by one bit. Bit 0 takes the XOR of state bits 15, 13, 12 and 10. Dither uses the state held before the advance of that same cycle.
- R10: After synchronous reset, `out_valid` and `out_data` are 0, the PRNG holds the seed, and both sync edge detectors see a previous level of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_data | input | DATA_W | Input pixel code |
| hsync | input | 1 | Horizontal sync level |
| vsync | input | 1 | Vertical sync level |
| dith_en | input | 1 | 1 = apply dither, 0 = pass through |
| amp_sel | input | 1 | 0 = wide (4-bit) offset, 1 = narrow (2-bit) offset |
| rate_sel | input | 2 | PRNG advance event: 00 pixel, 01 line, 1x frame |
| seed_clr | input | 1 | Holds the PRNG at its seed while high |
| out_valid | output | 1 | Output pixel qualifier |
| out_data | output | DATA_W | Dithered (or passed) pixel code |

## Verification
The scoreboard drives pixels at codes 0 and 255 with the wide offset. A design that wraps instead of clamping produces 248 for a low pixel or small codes for a bright one. Sync levels are held high across several pixels in line and frame mode. Advancing on the level instead of the edge, or on pixels in those modes, shows as a drifting offset sequence. Rate code 11 is exercised apart from 10, which catches a decoder that treats 11 as pixel rate. The seed-clear pulse is given while pixels and sync edges arrive, so a design that lets an advance win over the clear, or that reads the state after the advance, produces the wrong first offsets.

// File: rtl/dither_pkg.sv
// Package: shared encodings and constants for the pixel dither generator.
// Assumes: the rate field is two bits wide; codes 10 and 11 both mean frame rate.
package dither_pkg;

    // Advance-rate codes carried on rate_sel
    typedef enum logic [1:0] {
        RATE_PIXEL = 2'b00,
        RATE_LINE  = 2'b01,
        RATE_FRAME = 2'b10,
        RATE_FRAME_ALT = 2'b11
    } rate_e;

    // Default PRNG seed and feedback mask (bits 15,13,12,10)
    localparam logic [15:0] DEF_SEED = 16'hACE1;
    localparam logic [15:0] DEF_TAPS = 16'hB400;

    // Offset widths for the two amplitude settings
    localparam int WIDE_BITS   = 4;
    localparam int NARROW_BITS = 2;

endpackage

// File: rtl/dither_sync_edge.sv
// Module: dither_sync_edge
// Detects the rising edge of a level input that is synchronous to clk.
// Assumes: the level is already in the clk domain; the previous level is 0 after reset.
module dither_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic prev_q;

    // Remember the level seen in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level;
        end
    end

    // Edge is the current high level after a low one
    always_comb begin
        rise = level & ~prev_q;
    end

endmodule

// File: rtl/dither_lfsr.sv
// Module: dither_lfsr
// Fibonacci shift register: it shifts left and feeds the XOR of the tapped bits into bit 0.
// Assumes: TAPS and SEED describe a maximal-length sequence and SEED is nonzero;
// clr takes priority over step.
module dither_lfsr #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  SEED = 16'hACE1,
    parameter logic [W-1:0]  TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] state
);

    logic [W-1:0] state_q;
    logic [W-1:0] state_nxt;
    logic         fb;

    // Feedback bit and shifted next state
    always_comb begin
        fb        = ^(state_q & TAPS);
        state_nxt = {state_q[W-2:0], fb};
    end

    // State register: seed on reset or clear, else advance on step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (clr) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= state_nxt;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/dither_apply.sv
// Module: dither_apply
// Turns the low PRNG bits into a signed offset, adds it to the pixel, clamps the sum
// and registers the result with its valid flag (one cycle of latency).
// Assumes: NARROW_BITS < WIDE_BITS <= PRNG_W and WIDE_BITS <= DATA_W.
module dither_apply #(
    parameter int DATA_W      = 8,
    parameter int PRNG_W      = 16,
    parameter int WIDE_BITS   = 4,
    parameter int NARROW_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              dith_en,
    input  logic              amp_sel,
    input  logic [PRNG_W-1:0] prng,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int SUM_W = DATA_W + 2;
    localparam logic signed [SUM_W-1:0] MAX_CODE = SUM_W'((1 << DATA_W) - 1);

    logic signed [SUM_W-1:0] offset;
    logic signed [SUM_W-1:0] sum;
    logic [DATA_W-1:0]       clamped;
    logic [DATA_W-1:0]       result;

    // Sign-extend the selected number of low PRNG bits
    always_comb begin
        if (amp_sel) begin
            offset = SUM_W'($signed(prng[NARROW_BITS-1:0]));
        end else begin
            offset = SUM_W'($signed(prng[WIDE_BITS-1:0]));
        end
    end

    // Add the offset and saturate into the output code range
    always_comb begin
        sum = $signed({2'b00, in_data}) + offset;
        if (sum < 0) begin
            clamped = '0;
        end else if (sum > MAX_CODE) begin
            clamped = '1;
        end else begin
            clamped = sum[DATA_W-1:0];
        end
        result = dith_en ? clamped : in_data;
    end

    // Output register: result and valid move together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= result;
            end
        end
    end

endmodule

// File: rtl/pixel_dither_gen.sv
// Module: pixel_dither_gen (top)
// Adds PRNG dither to a pixel stream. The PRNG advances per pixel, per line or per
// frame, as rate_sel selects. A seed-clear control loads the PRNG with its fixed seed.
// Assumes: hsync and vsync are synchronous to clk; controls change between pixels.
module pixel_dither_gen
    import dither_pkg::*;
#(
    parameter int                DATA_W = 8,
    parameter int                PRNG_W = 16,
    parameter logic [PRNG_W-1:0] SEED   = DEF_SEED,
    parameter logic [PRNG_W-1:0] TAPS   = DEF_TAPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              dith_en,
    input  logic              amp_sel,
    input  logic [1:0]        rate_sel,
    input  logic              seed_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int N_SYNC = 2;

    logic [N_SYNC-1:0] sync_lvl;
    logic [N_SYNC-1:0] sync_rise;
    logic              prng_step;
    logic [PRNG_W-1:0] prng_q;
    rate_e             rate;

    assign sync_lvl = {vsync, hsync};

    // One rising-edge detector for each sync input
    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        dither_sync_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .level (sync_lvl[g]),
            .rise  (sync_rise[g])
        );
    end

    // Pick the event that advances the PRNG
    always_comb begin
        rate = rate_e'(rate_sel);
        case (rate)
            RATE_PIXEL: prng_step = in_valid;
            RATE_LINE:  prng_step = sync_rise[0];
            default:    prng_step = sync_rise[1];
        endcase
    end

    dither_lfsr #(
        .W    (PRNG_W),
        .SEED (SEED),
        .TAPS (TAPS)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (seed_clr),
        .step  (prng_step),
        .state (prng_q)
    );

    dither_apply #(
        .DATA_W      (DATA_W),
        .PRNG_W      (PRNG_W),
        .WIDE_BITS   (WIDE_BITS),
        .NARROW_BITS (NARROW_BITS)
    ) u_apply (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .dith_en   (dith_en),
        .amp_sel   (amp_sel),
        .prng      (prng_q),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/pixel_dither_gen_chk.sv
// Module: pixel_dither_gen_chk
// Temporal checks on the dither generator, bound into every instance of the top.
// Assumes: the PRNG state is taken from the top-level prng_q net.
module pixel_dither_gen_chk #(
    parameter int                DATA_W = 8,
    parameter int                PRNG_W = 16,
    parameter logic [PRNG_W-1:0] SEED   = 16'hACE1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              hsync,
    input logic              vsync,
    input logic              dith_en,
    input logic              amp_sel,
    input logic [1:0]        rate_sel,
    input logic              seed_clr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [PRNG_W-1:0] prng_q
);

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dith_en) |=> (out_data == $past(in_data)));

    p_wide_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dith_en && !amp_sel) |=>
        (($signed({2'b00, out_data}) - $signed({2'b00, $past(in_data)})) >= -8 &&
         ($signed({2'b00, out_data}) - $signed({2'b00, $past(in_data)})) <= 7));

    p_narrow_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dith_en && amp_sel) |=>
        (($signed({2'b00, out_data}) - $signed({2'b00, $past(in_data)})) >= -2 &&
         ($signed({2'b00, out_data}) - $signed({2'b00, $past(in_data)})) <= 1));

    p_line_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 2'b01 && !hsync && !seed_clr) |=> $stable(prng_q));

    p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel[1] && !vsync && !seed_clr) |=> $stable(prng_q));

    p_pixel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 2'b00 && !in_valid && !seed_clr) |=> $stable(prng_q));

    p_seed_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seed_clr |=> (prng_q == SEED));

endmodule

bind pixel_dither_gen pixel_dither_gen_chk #(
    .DATA_W (DATA_W),
    .PRNG_W (PRNG_W),
    .SEED   (SEED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .hsync     (hsync),
    .vsync     (vsync),
    .dith_en   (dith_en),
    .amp_sel   (amp_sel),
    .rate_sel  (rate_sel),
    .seed_clr  (seed_clr),
    .out_valid (out_valid),
    .out_data  (out_data),
    .prng_q    (prng_q)
);

// File: tb/test_pixel_dither_gen.sv
module test_pixel_dither_gen;

    localparam int          DW   = 8;
    localparam logic [15:0] SEED = 16'hACE1;
    localparam time         CYC  = 8ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          hsync = 1'b0;
    logic          vsync = 1'b0;
    logic          dith_en = 1'b0;
    logic          amp_sel = 1'b0;
    logic [1:0]    rate_sel = 2'b00;
    logic          seed_clr = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R10";

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    // Reference model state
    logic [15:0] m_lfsr = SEED;
    logic        m_ph = 1'b0;
    logic        m_pv = 1'b0;

    always #(CYC / 2) clk = ~clk;

    pixel_dither_gen i_pixel_dither_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .hsync     (hsync),
        .vsync     (vsync),
        .dith_en   (dith_en),
        .amp_sel   (amp_sel),
        .rate_sel  (rate_sel),
        .seed_clr  (seed_clr),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R9: shift left, bit 0 = s15 ^ s13 ^ s12 ^ s10
    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [DW-1:0] model_out(input logic [DW-1:0] d);
        int off;
        int sum;
        if (!dith_en) return d;
        off = amp_sel ? int'($signed(m_lfsr[1:0])) : int'($signed(m_lfsr[3:0]));
        sum = int'(d) + off;
        if (sum < 0) sum = 0;
        if (sum > 255) sum = 255;
        return DW'(sum);
    endfunction

    task automatic drive(input logic v, input logic [DW-1:0] d,
                         input logic hs, input logic vs);
        logic stp;
        in_valid = v;
        in_data  = d;
        hsync    = hs;
        vsync    = vs;
        if (v) begin
            exp_q.push_back(model_out(d));
            tag_q.push_back(cur_req);
        end
        case (rate_sel)
            2'b00:   stp = v;
            2'b01:   stp = hs && !m_ph;
            default: stp = vs && !m_pv;
        endcase
        if (seed_clr) m_lfsr = SEED;
        else if (stp) m_lfsr = nxt(m_lfsr);
        m_ph = hs;
        m_pv = vs;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each output pixel against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R1: actual unexpected pixel %0h expected none", out_data);
            end else begin
                check(tag_q.pop_front(), 32'(out_data), 32'(exp_q.pop_front()));
            end
        end
    end

    // Pixel burst with sync pulses: hs/vs go high every 'per' pixels for 'w' cycles
    task automatic burst(input int n, input int per, input int w, input bit use_h,
                         input bit use_v, input int base);
        for (int i = 0; i < n; i++) begin
            logic s;
            s = (per > 0) && ((i % per) < w);
            drive(((i % 3) != 2), DW'(base + i * 37), use_h && s, use_v && s);
        end
    endtask

    initial begin
        #(CYC * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R10: reset state
        check("R10", 32'(out_valid), 32'd0);
        check("R10", 32'(out_data), 32'd0);
        rst_n = 1'b1;
        drive(0, 0, 0, 0);
        check("R10", 32'(out_valid), 32'd0);

        // R1: bypass with several patterns
        cur_req = "R1";
        for (int i = 0; i < 20; i++) drive(1, DW'(i * 13 + 5), 0, 0);
        burst(20, 0, 0, 0, 0, 250);

        // R2 and R5/R9: wide offset, pixel rate
        dith_en = 1'b1;
        cur_req = "R2";
        burst(40, 0, 0, 0, 0, 100);
        cur_req = "R9";
        for (int i = 0; i < 40; i++) drive(1, 8'd128, 0, 0);
        cur_req = "R5";
        for (int i = 0; i < 10; i++) drive(i[0], 8'd60, 1, 1);

        // R3: narrow offset
        amp_sel = 1'b1;
        cur_req = "R3";
        burst(40, 0, 0, 0, 0, 30);

        // R4: clamping at both ends with the wide offset
        amp_sel = 1'b0;
        cur_req = "R4";
        for (int i = 0; i < 40; i++) drive(1, (i % 4 == 0) ? 8'd0 : (i % 4 == 1) ? 8'd255 :
                                              (i % 4 == 2) ? 8'd3 : 8'd252, 0, 0);

        // R6: line rate, sync held high several cycles
        rate_sel = 2'b01;
        cur_req = "R6";
        burst(60, 7, 3, 1, 1, 77);

        // R7: frame rate, both codes
        rate_sel = 2'b10;
        cur_req = "R7";
        burst(60, 9, 4, 1, 1, 11);
        rate_sel = 2'b11;
        burst(60, 5, 2, 1, 1, 200);

        // R8: seed clear held with pixels and edges arriving
        rate_sel = 2'b00;
        cur_req = "R8";
        seed_clr = 1'b1;
        drive(1, 8'd128, 0, 0);
        drive(1, 8'd128, 1, 1);
        drive(1, 8'd128, 0, 0);
        seed_clr = 1'b0;
        for (int i = 0; i < 20; i++) drive(1, 8'd128, 0, 0);
        rate_sel = 2'b01;
        seed_clr = 1'b1;
        drive(1, 8'd128, 1, 0);
        seed_clr = 1'b0;
        burst(30, 4, 1, 1, 0, 128);

        drive(0, 0, 0, 0);
        drive(0, 0, 0, 0);
        check("R1", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule